// File: doc/BRIEF.md
# Gated Two-Channel Radiation Pulse Counter

This peripheral counts detector pulses inside a timed acquisition window on two independent channels, alpha and gamma. Each detector input is an asynchronous, already-discriminated rectangular pulse. Three register stages bring it into the clock domain. A rising-edge detector then turns every external pulse into exactly one single-cycle event, however long the pulse is held high. While a channel is running, a per-channel prescaler divides the clock into one-second ticks. A seconds counter ends the window when it reaches the programmed length. The total for that window is then pushed into the channel's result FIFO, and the next window starts at once.

A host processor drives the block through a small memory-mapped slave with a read latency of zero. A command word carries a channel select plus start, stop, set-time and clear-FIFO actions. A status word shows, per channel, FIFO empty, FIFO full, running and a sticky overflow flag. Reading a channel's result address returns the oldest stored total and removes it from the FIFO.

Top module: `pulse_tally`

## Requirements
- R1: After reset both channels are idle and their FIFOs are empty with no overflow. Status (address 1) then reads 0x11. The layout is {overflow, running, full, empty} in bits 3:0 for alpha and in bits 7:4 for gamma. Result reads (address 2 for alpha, 3 for gamma) return 0.
- R2: Each rising edge on a detector input adds exactly one to the running count, whether the pulse is high for one cycle or for many.
- R3: A command write to address 0 acts on the channel chosen by bit 3 (0 = alpha, 1 = gamma). Bit 4 loads the window length from bits 31:16. Bit 0 starts counting from zero. A window lasts length × DIV clock cycles, and at its end the window total is pushed into that channel's FIFO.
- R4: Command bit 1 (stop) halts the channel at once and discards the partial count. It wins over start in the same write.
- R5: While a channel is running, each completed window is followed immediately by a new window that counts from zero. Every window pushes its own total.
- R6: Results leave the FIFO in the order they were stored. A read of the result address pops one entry. A read of an empty FIFO returns 0 and changes nothing.
- R7: If a window ends while its FIFO is full, the total is dropped and the channel's overflow bit sets and stays set.
- R8: Command bit 2 (clear) empties the selected FIFO and clears its overflow bit.
- R9: The two channels time, count and store independently when both are active at the same time.
- R10: The count saturates at its maximum value (2^CNT_W − 1) instead of wrapping.
- R11: A start whose window length would be zero is ignored, and the channel stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 command/length, 1 status, 2 alpha result, 3 gamma result |
| bus_read | input | 1 | Read strobe (pops at result addresses) |
| bus_write | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| det_alpha | input | 1 | Asynchronous alpha detector pulse |
| det_gamma | input | 1 | Asynchronous gamma detector pulse |

## Verification
The hardest state to reach is a window boundary that meets a full FIFO. The rejected total and the sticky flag can only be seen after several back-to-back windows have run with nobody reading. The bench sets a one-second window and lets the channel restart itself five times against a four-entry FIFO. It then reads status before popping anything. Saturation is reached in the same spirit: the counter width is shrunk to four bits so that a burst of twenty short pulses drives it to its limit inside one window.

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int DIV   = 250_000_000,
  parameter int CNT_W = 32,
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_read,
  input  logic        bus_write,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        det_alpha,
  input  logic        det_gamma
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [1:0]       det;
  logic [2:0]       sh   [2];
  logic [1:0]       ev, run, ovf, tick, win_end, push, pop, hit, clr;
  logic [PW-1:0]    pre  [2];
  logic [15:0]      secs [2];
  logic [15:0]      tlen [2];
  logic [15:0]      newt [2];
  logic [CNT_W-1:0] cnt  [2];
  logic [CNT_W-1:0] cnt_nx [2];
  logic [CNT_W-1:0] mem  [2][DEPTH];
  logic [AW-1:0]    wp   [2];
  logic [AW-1:0]    rp   [2];
  logic [CW-1:0]    fill [2];
  logic [3:0]       stat [2];
  logic [31:0]      head [2];

  wire unused_bits = ^bus_wdata[15:5];

  assign det = {det_gamma, det_alpha};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      ev[i]      = sh[i][1] & ~sh[i][2];
      hit[i]     = bus_write && bus_addr == 2'd0 && bus_wdata[3] == i[0];
      clr[i]     = hit[i] && bus_wdata[2];
      newt[i]    = bus_wdata[4] ? bus_wdata[31:16] : tlen[i];
      tick[i]    = run[i] && pre[i] == PW'(DIV - 1);
      win_end[i] = tick[i] && (secs[i] + 16'd1 >= tlen[i]);
      cnt_nx[i]  = (cnt[i] == CMAX) ? cnt[i] : cnt[i] + CNT_W'(ev[i]);
      push[i]    = win_end[i] && fill[i] != CW'(DEPTH) && !clr[i];
      pop[i]     = bus_read && bus_addr == (2'd2 + 2'(i)) && fill[i] != '0 && !clr[i];
      stat[i]    = {ovf[i], run[i], fill[i] == CW'(DEPTH), fill[i] == '0};
      head[i]    = (fill[i] == '0) ? 32'd0 : 32'(mem[i][rp[i]]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        sh[i] <= '0; pre[i] <= '0; secs[i] <= '0; tlen[i] <= '0; cnt[i] <= '0;
        wp[i] <= '0; rp[i] <= '0; fill[i] <= '0;
      end
      run <= '0;
      ovf <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        sh[i] <= {sh[i][1:0], det[i]};
        if (hit[i] && bus_wdata[4]) tlen[i] <= bus_wdata[31:16];
        if (hit[i] && bus_wdata[1]) begin
          run[i] <= 1'b0;
          cnt[i] <= '0;
        end else if (hit[i] && bus_wdata[0] && newt[i] != 16'd0) begin
          run[i] <= 1'b1; pre[i] <= '0; secs[i] <= '0; cnt[i] <= '0;
        end else if (run[i]) begin
          pre[i]  <= tick[i] ? '0 : pre[i] + PW'(1);
          secs[i] <= win_end[i] ? 16'd0 : (tick[i] ? secs[i] + 16'd1 : secs[i]);
          cnt[i]  <= win_end[i] ? '0 : cnt_nx[i];
        end
        if (clr[i]) begin
          wp[i] <= '0; rp[i] <= '0; fill[i] <= '0; ovf[i] <= 1'b0;
        end else begin
          if (push[i]) begin
            mem[i][wp[i]] <= cnt_nx[i];
            wp[i] <= wp[i] + AW'(1);
          end
          if (pop[i]) rp[i] <= rp[i] + AW'(1);
          fill[i] <= fill[i] + CW'(push[i]) - CW'(pop[i]);
          if (win_end[i] && !push[i]) ovf[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {tlen[1], tlen[0]};
      2'd1:    bus_rdata = {24'd0, stat[1], stat[0]};
      2'd2:    bus_rdata = head[0];
      default: bus_rdata = head[1];
    endcase
  end
endmodule

// File: rtl/pulse_tally_chk.sv
module pulse_tally_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_write,
  input logic [1:0]    bus_addr,
  input logic [3:0]    cmd,
  input logic [1:0]    ev,
  input logic [1:0]    run,
  input logic [1:0]    ovf,
  input logic [1:0]    win_end,
  input logic [CW-1:0] fill_a,
  input logic [CW-1:0] fill_g
);
  wire cmd_a = bus_write && bus_addr == 2'd0 && !cmd[3];

  assert_event_single_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> !ev[0]);
  assert_event_single_g_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev[1] |=> !ev[1]);
  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a && cmd[1] |=> !run[0]);
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_a <= CW'(DEPTH) && fill_g <= CW'(DEPTH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_end[0] && fill_a == CW'(DEPTH) && !(cmd_a && cmd[2]) |=> ovf[0] && $stable(fill_a));
  assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_a && cmd[2] |=> fill_a == '0 && !ovf[0]);
endmodule

bind pulse_tally pulse_tally_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_write(bus_write), .bus_addr(bus_addr),
  .cmd(bus_wdata[3:0]), .ev(ev), .run(run), .ovf(ovf), .win_end(win_end),
  .fill_a(fill[0]), .fill_g(fill[1])
);

// File: tb/pulse_tally_tb_top.sv
module pulse_tally_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_read = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        det_alpha = 1'b0, det_gamma = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_tally #(.DIV(10), .CNT_W(4), .DEPTH(4)) dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = d; bus_write = 1'b1;
    @(negedge clk); bus_write = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_read = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_read = 1'b0;
  endtask

  function automatic logic [31:0] cmd(bit ch, bit st, bit sp, bit cl, bit ld, int secs);
    return {16'(secs), 11'd0, ld, ch, cl, sp, st};
  endfunction

  task automatic pulse_a(int hi, int lo);
    @(negedge clk); det_alpha = 1'b1;
    repeat (hi) @(negedge clk);
    det_alpha = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd1, d); check("R1 status", d, 32'h11);
    rd(2'd2, d); check("R1 alpha result", d, 0);
    rd(2'd3, d); check("R1 gamma result", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(cmd(0, 1, 0, 0, 1, 3));
    repeat (3) pulse_a(1, 3);
    pulse_a(8, 3);
    rd(2'd1, d); check("R3 running", d & 32'h4, 32'h4);
    idle(8);
    wr(cmd(0, 0, 1, 0, 0, 0));
    rd(2'd1, d); check("R3 one result stored", d & 32'hF, 32'h0);
    rd(2'd2, d); check("R2 short and long pulses", d, 4);
    rd(2'd2, d); check("R6 empty read", d, 0);
    rd(2'd0, d); check("R3 length readback", d & 32'hFFFF, 3);
  endtask

  task automatic t_parallel();
    logic [31:0] d;
    wr(cmd(0, 1, 0, 0, 1, 2));
    wr(cmd(1, 1, 0, 0, 1, 2));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); det_gamma = 1'b1; det_alpha = (k < 2);
      @(negedge clk); det_gamma = 1'b0; det_alpha = 1'b0;
      @(negedge clk);
    end
    idle(10);
    wr(cmd(0, 0, 1, 0, 0, 0));
    wr(cmd(1, 0, 1, 0, 0, 0));
    rd(2'd2, d); check("R9 alpha total", d, 2);
    rd(2'd3, d); check("R9 gamma total", d, 5);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(cmd(0, 1, 0, 0, 1, 3));
    repeat (3) pulse_a(1, 2);
    wr(cmd(0, 0, 1, 0, 0, 0));
    idle(40);
    rd(2'd1, d); check("R4 idle and empty", d & 32'hF, 32'h1);
    rd(2'd2, d); check("R4 partial discarded", d, 0);
    wr(cmd(0, 1, 1, 0, 0, 0));
    rd(2'd1, d); check("R4 stop beats start", d & 32'h4, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(cmd(0, 1, 0, 0, 1, 2));
    repeat (2) pulse_a(1, 3);
    idle(35);
    wr(cmd(0, 0, 1, 0, 0, 0));
    rd(2'd2, d); check("R5 first window", d, 2);
    rd(2'd2, d); check("R5 second window", d, 0);
    rd(2'd1, d); check("R6 drained", d & 32'h1, 1);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    wr(cmd(0, 1, 0, 0, 1, 1));
    idle(54);
    wr(cmd(0, 0, 1, 0, 0, 0));
    rd(2'd1, d); check("R7 full and overflow", d & 32'hF, 32'hA);
    rd(2'd2, d); check("R6 pop from full", d, 0);
    rd(2'd1, d); check("R7 overflow sticky", d & 32'h8, 32'h8);
    wr(cmd(0, 0, 0, 1, 0, 0));
    rd(2'd1, d); check("R8 cleared", d & 32'hF, 32'h1);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    wr(cmd(0, 1, 0, 0, 1, 6));
    repeat (20) pulse_a(1, 2);
    idle(25);
    wr(cmd(0, 0, 1, 0, 0, 0));
    rd(2'd2, d); check("R10 saturated total", d, 15);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(cmd(1, 1, 0, 0, 1, 0));
    idle(3);
    rd(2'd1, d); check("R11 zero length ignored", d & 32'h40, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_parallel();
    t_stop();
    t_restart();
    t_overflow();
    t_saturate();
    t_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule